// File: doc/BRIEF.md
# Video Pixel-to-Word Packer

This block takes a raster stream of 24-bit colour pixels and turns it into a stream of 32-bit words that a memory-writing sink can store without wasted bytes. Every group of four pixels becomes three full words. The packing is byte-dense and little-endian, so one pixel often straddles two words. A pixel source feeds it one pixel per handshake, with a start-of-frame flag and an end-of-line flag. A stream sink drains it through a ready/valid port that carries the same two markers as side flags.

Internally a two-bit phase counter tracks the position inside the current group of four. A carry register keeps the bytes of the last pixel that did not fit in the word just built. The first pixel of a group only fills the carry register. Each of the other three completes a word and loads it into a registered output stage. The sink may stall at any time. The source is then held off only when a new word would have to overwrite one that is still waiting. Lines should be a multiple of four pixels long, so that every line ends on a word boundary.

Top module: `pixel_word_packer`

## Requirements
- R1: Packing layout, with pixel n of a group written Pn and bits [7:0] called its low byte: word 0 = {P1[7:0], P0[23:0]}, word 1 = {P2[15:0], P1[23:8]}, word 2 = {P3[23:0], P2[23:16]}.
- R2: Four accepted pixels produce exactly three output words. The first pixel of a group produces no word, and each of the other three completes one word.
- R3: With the source valid and the sink ready held high, one pixel is accepted every clock and the output valid is high on three of every four clocks. Across a 16-pixel burst that starts from idle, 12 of 17 consecutive cycles show valid and no cycle stalls the source.
- R4: A transfer takes place only on a cycle where both valid and ready are high. While the output is valid and the sink is not ready, the output word and its flags stay unchanged on the next cycle.
- R5: Under any pattern of sink backpressure, no pixel is dropped and no word is duplicated. The sink receives exactly the words given by R1, in order.
- R6: The start-of-frame flag (tuser) is high on the word that holds the first byte of the flagged pixel: word 0 for P0 or P1, word 1 for P2, word 2 for P3. It is low on every other word.
- R7: The end-of-line flag (tlast) is high on the word that holds the last byte of the flagged pixel: word 0 for P0, word 1 for P1, word 2 for P2 or P3. It is low on every other word.
- R8: A synchronous active-high reset clears the output valid, the group phase and any partial word, so the first pixel accepted after reset starts a new group.
- R9: The source ready is high whenever the output register is empty, the sink is ready, or the incoming pixel is the first of a group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_pix | input | 24 | Pixel {blue, green, red}, red in bits 7:0 |
| s_sof | input | 1 | Pixel is the first of a frame |
| s_eol | input | 1 | Pixel is the last of a line |
| s_valid | input | 1 | Source offers a pixel |
| s_ready | output | 1 | Packer accepts the pixel this cycle |
| m_tdata | output | 32 | Packed output word |
| m_tvalid | output | 1 | Output word is valid |
| m_tready | input | 1 | Sink accepts the word this cycle |
| m_tuser | output | 1 | Word carries the start of a frame |
| m_tlast | output | 1 | Word ends a line |

## Verification
The bench builds the packer with its default colour width of 8 bits. This gives 24-bit pixels, 32-bit words, four generated output lanes and three carry lanes, so every lane-select path of each phase is exercised. Frame flags are placed on every group position, not only at line ends, so each row of the flag-placement rules in R6 and R7 is covered. Three sink patterns (always ready, pseudo-random, alternating) bring out the stall-hold and no-loss behaviour. A reset in the middle of a group shows the phase restart.

// File: rtl/pxpk_pkg.sv
package pxpk_pkg;
  localparam int GROUP_PIX  = 4;
  localparam int PIX_LANES  = 3;
  localparam int WORD_LANES = 4;
  typedef logic [1:0] phase_t;
endpackage

// File: rtl/pxpk_lane_mux.sv
module pxpk_lane_mux
  import pxpk_pkg::*;
#(
  parameter int COLOR_W = 8,
  localparam int PIX_W  = PIX_LANES * COLOR_W,
  localparam int WORD_W = WORD_LANES * COLOR_W
) (
  input  phase_t            phase,
  input  logic [PIX_W-1:0]  pix,
  input  logic [PIX_W-1:0]  carry,
  output logic [WORD_W-1:0] word,
  output logic [PIX_W-1:0]  carry_nxt
);
  // Output lane j takes carry lanes first, then pixel lanes.
  for (genvar j = 0; j < WORD_LANES; j++) begin : g_word
    always_comb begin
      int held;
      int src;
      held = WORD_LANES - int'(phase);
      src  = (j >= held) ? (j - held) : 0;
      if (j < held && j < PIX_LANES)
        word[j*COLOR_W +: COLOR_W] = carry[j*COLOR_W +: COLOR_W];
      else if (j >= held)
        word[j*COLOR_W +: COLOR_W] = pix[src*COLOR_W +: COLOR_W];
      else
        word[j*COLOR_W +: COLOR_W] = '0;
    end
  end

  // Leftover pixel lanes move down into the carry register.
  for (genvar j = 0; j < PIX_LANES; j++) begin : g_carry
    always_comb begin
      int src;
      src = j + int'(phase);
      if (src < PIX_LANES)
        carry_nxt[j*COLOR_W +: COLOR_W] = pix[src*COLOR_W +: COLOR_W];
      else
        carry_nxt[j*COLOR_W +: COLOR_W] = '0;
    end
  end
endmodule

// File: rtl/pxpk_out_reg.sv
module pxpk_out_reg #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              ld_user,
  input  logic              ld_last,
  input  logic              m_tready,
  output logic [WORD_W-1:0] m_tdata,
  output logic              m_tvalid,
  output logic              m_tuser,
  output logic              m_tlast
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m_tvalid <= 1'b0;
    end else begin
      m_tvalid <= load | (m_tvalid & ~m_tready);
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      m_tdata <= ld_data;
      m_tuser <= ld_user;
      m_tlast <= ld_last;
    end
  end

  // R4: a stalled word and its flags must not change
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)
                                 && $stable(m_tuser) && $stable(m_tlast)));
endmodule

// File: rtl/pixel_word_packer.sv
module pixel_word_packer
  import pxpk_pkg::*;
#(
  parameter int COLOR_W = 8,
  localparam int PIX_W  = PIX_LANES * COLOR_W,
  localparam int WORD_W = WORD_LANES * COLOR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  s_pix,
  input  logic              s_sof,
  input  logic              s_eol,
  input  logic              s_valid,
  output logic              s_ready,
  output logic [WORD_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tuser,
  output logic              m_tlast
);
  localparam phase_t LAST_PHASE = phase_t'(GROUP_PIX - 1);

  phase_t             phase;
  logic [PIX_W-1:0]   carry;
  logic [PIX_W-1:0]   carry_nxt;
  logic [WORD_W-1:0]  word;
  logic               pend_user;
  logic               pend_last;
  logic               accept;
  logic               emit;
  logic               word_user;
  logic               word_last;

  assign s_ready   = (phase == '0) | ~m_tvalid | m_tready;
  assign accept    = s_valid & s_ready;
  assign emit      = accept & (phase != '0);
  assign word_user = pend_user | (s_sof & (phase != '0));
  assign word_last = pend_last | (s_eol & (phase == LAST_PHASE));

  pxpk_lane_mux #(.COLOR_W(COLOR_W)) u_mux (
    .phase     (phase),
    .pix       (s_pix),
    .carry     (carry),
    .word      (word),
    .carry_nxt (carry_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      carry     <= '0;
      pend_user <= 1'b0;
      pend_last <= 1'b0;
    end else if (accept) begin
      phase     <= phase + phase_t'(1);
      carry     <= carry_nxt;
      pend_user <= (phase == '0) ? s_sof : 1'b0;
      pend_last <= (phase != LAST_PHASE) ? s_eol : 1'b0;
    end
  end

  pxpk_out_reg #(.WORD_W(WORD_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (emit),
    .ld_data  (word),
    .ld_user  (word_user),
    .ld_last  (word_last),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tuser  (m_tuser),
    .m_tlast  (m_tlast)
  );

  // R9: an empty output register never holds off the source
  assert_ready_when_free_R9: assert property (@(posedge clk) disable iff (rst)
    !m_tvalid |-> s_ready);

  // R2: a group's first pixel produces no word
  assert_first_no_word_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && phase == '0 && m_tready) |=> !m_tvalid);

  // R5: a new word only appears after an accepted pixel
  assert_word_from_pixel_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(m_tvalid) |-> $past(s_valid && s_ready));

  // R8: the cycle after reset shows no valid word
  assert_reset_clear_R8: assert property (@(posedge clk)
    $past(rst) |-> !m_tvalid);
endmodule

// File: tb/test_pixel_word_packer.sv
module test_pixel_word_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] s_pix = '0;
  logic        s_sof = 1'b0;
  logic        s_eol = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b1;
  logic        m_tuser;
  logic        m_tlast;

  always #2.5 clk = ~clk;

  pixel_word_packer i_pixel_word_packer (
    .clk(clk), .rst(rst), .s_pix(s_pix), .s_sof(s_sof), .s_eol(s_eol),
    .s_valid(s_valid), .s_ready(s_ready), .m_tdata(m_tdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tuser(m_tuser),
    .m_tlast(m_tlast)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit mon_on = 0;
  int pops = 0;
  int pushes = 0;
  int stalls = 0;
  int vcount = 0;
  bit rate_on = 0;

  logic [33:0] expq[$];
  int bph = 0;
  logic [23:0] bp [4];
  logic        bs [4];
  logic        be [4];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    case (ready_mode)
      0: m_tready = 1'b1;
      1: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        m_tready = lfsr[0] | lfsr[3];
      end
      default: m_tready = ~m_tready;
    endcase
  end

  // Scoreboard model of the packing rules R1, R6, R7
  task automatic model_push(input logic [23:0] p, input logic sf, input logic el);
    logic [33:0] e;
    bp[bph] = p; bs[bph] = sf; be[bph] = el;
    case (bph)
      1: e = {bs[0] | bs[1], be[0], bp[1][7:0], bp[0]};
      2: e = {bs[2], be[1], bp[2][15:0], bp[1][23:8]};
      3: e = {bs[3], be[2] | be[3], bp[3], bp[2][23:16]};
      default: e = '0;
    endcase
    if (bph != 0) begin
      expq.push_back(e);
      pushes++;
    end
    bph = (bph + 1) % 4;
  endtask

  // Monitor: samples 1 ns before each rising edge
  logic [33:0] held;
  bit          was_stall = 0;
  always @(negedge clk) begin
    #1.5;
    if (mon_on) begin
      if (was_stall)
        check(m_tvalid && {m_tuser, m_tlast, m_tdata} == held, "R4",
              "stalled word changed", {m_tvalid, m_tuser, m_tlast, m_tdata},
              {1'b1, held});
      if (!m_tvalid)
        check(s_ready, "R9", "ready low with empty output", s_ready, 1);
      if (m_tvalid && m_tready) begin
        pops++;
        if (expq.size() == 0)
          check(0, "R5", "unexpected word", {m_tuser, m_tlast, m_tdata}, 0);
        else begin
          logic [33:0] e;
          e = expq.pop_front();
          check({m_tuser, m_tlast, m_tdata} == e, "R1/R6/R7",
                "word {user,last,data}", {m_tuser, m_tlast, m_tdata}, e);
        end
      end
      was_stall = m_tvalid && !m_tready;
      held = {m_tuser, m_tlast, m_tdata};
    end
  end

  task automatic drive_pix(input logic [23:0] p, input logic sf, input logic el);
    @(negedge clk);
    s_pix = p; s_sof = sf; s_eol = el; s_valid = 1'b1;
    #2;
    if (rate_on) vcount += int'(m_tvalid);
    while (!s_ready) begin
      stalls++;
      @(negedge clk);
      #2;
      if (rate_on) vcount += int'(m_tvalid);
    end
    model_push(p, sf, el);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b0; s_sof = 1'b0; s_eol = 1'b0;
      #2;
      if (rate_on) vcount += int'(m_tvalid);
    end
  endtask

  task automatic drain;
    int guard;
    guard = 0;
    idle(1);
    while ((expq.size() != 0 || m_tvalid) && guard < 2000) begin
      idle(1);
      guard++;
    end
    check(expq.size() == 0, "R5", "words missing at drain", expq.size(), 0);
  endtask

  task automatic do_reset;
    mon_on = 0;
    @(negedge clk);
    rst = 1'b1; s_valid = 1'b0;
    @(negedge clk);
    #2;
    check(!m_tvalid, "R8", "valid during reset", m_tvalid, 0);
    check(s_ready, "R8", "ready during reset", s_ready, 1);
    @(negedge clk);
    rst = 1'b0;
    expq.delete();
    bph = 0;
    was_stall = 0;
    #2;
    check(!m_tvalid, "R8", "valid after reset", m_tvalid, 0);
    mon_on = 1;
  endtask

  function automatic logic [23:0] pixval(input int n);
    return 24'(n * 32'h0001_0F3B + 32'h00A5_1C07);
  endfunction

  // A frame of lines with flags on line boundaries
  task automatic send_frame(input int lines, input int len, input int base);
    for (int l = 0; l < lines; l++)
      for (int x = 0; x < len; x++)
        drive_pix(pixval(base + l * len + x), (l == 0 && x == 0), (x == len - 1));
  endtask

  initial begin
    do_reset();

    // R3: full-rate burst from idle
    ready_mode = 0;
    stalls = 0; vcount = 0; rate_on = 1;
    for (int i = 0; i < 16; i++) drive_pix(pixval(i), i == 0, i == 15);
    idle(1);
    rate_on = 0;
    check(vcount == 12, "R3", "valid cycles in 17", vcount, 12);
    check(stalls == 0, "R3", "source stalls at full rate", stalls, 0);
    drain();

    // R2: word count over a frame
    pops = 0; pushes = 0;
    send_frame(3, 8, 100);
    drain();
    check(pops == 18, "R2", "words for 24 pixels", pops, 18);

    // R5, R4: random backpressure
    ready_mode = 1;
    pops = 0;
    send_frame(4, 12, 400);
    drain();
    check(pops == 36, "R5", "words under random stall", pops, 36);

    // R5, R4: alternating backpressure
    ready_mode = 2;
    pops = 0;
    send_frame(2, 16, 900);
    drain();
    check(pops == 24, "R5", "words under alternating stall", pops, 24);

    // R6, R7: flags on every group position
    ready_mode = 1;
    for (int pos = 0; pos < 4; pos++)
      for (int i = 0; i < 4; i++)
        drive_pix(pixval(2000 + pos * 4 + i), i == pos, i == pos);
    drain();

    // R8: reset in the middle of a group
    ready_mode = 0;
    drive_pix(pixval(7), 1'b0, 1'b0);
    drive_pix(pixval(8), 1'b0, 1'b0);
    do_reset();
    pops = 0;
    for (int i = 0; i < 4; i++) drive_pix(pixval(50 + i), i == 0, i == 3);
    drain();
    check(pops == 3, "R8", "words after mid-group reset", pops, 3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule